// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Lock Detector

This block sits behind a bit-rate sampler on a serial link whose 12-bit symbols carry their own framing: a high start bit, ten payload bits, and a low stop bit. It receives one bit per clock and keeps a 12-bit window of the stream. It checks every one of the 12 possible symbol phases for the high-then-low framing pair. It declares alignment only when a single phase has been consistent. It then delivers each payload as a parallel word with a one-cycle strobe, and reports alignment on an active-low lock output.

When a payload pattern puts a low bit next to a high bit in every symbol, a second phase also shows a valid framing pair. The search refuses to lock while more than one phase qualifies. A repeating symbol of six ones followed by six zeros has exactly one qualifying phase, so the far end can send it to force fast alignment.

Once aligned, the block watches only the framing pair at its locked phase. It drops lock after a fixed number of consecutive bad pairs and then searches all phases again. An output-enable input blanks the word and the strobe. A sleep input blanks everything, including lock, and clears all alignment state.

Top module: `frame_aligner`

## Requirements
- R1: Each symbol is sent start bit first, then payload bit 0 through bit 9, then the stop bit. A boundary is valid when the bit eleven positions before the current bit is 1 and the current bit is 0.
- R2: After reset, lock_n is 1, word_stb is 0 and word is 0.
- R3: While lock_n is 1, word is 0 and word_stb is 0. A strobe occurs only while lock_n is 0.
- R4: While locked, every symbol at the locked phase produces exactly one word_stb pulse. The pulse comes one cycle after the stop bit is sampled, and word bit i equals payload bit i of that symbol.
- R5: Each phase counts its consecutive valid pairs up to MATCH_N. A phase whose count is already MATCH_N acquires lock on its next valid pair, provided no other phase is at MATCH_N. A repeated symbol with exactly one cyclic 0-to-1 transition (start bit, payload, stop bit taken as a ring) therefore reaches lock_n = 0 within MATCH_N+4 symbols.
- R6: A repeated symbol with more than one cyclic 0-to-1 transition never brings lock_n low. For example, payload bit k held 0 beside bit k+1 held 1, for k from 0 to 8.
- R7: The sync symbol (six ones, then six zeros) leads to lock. Its delivered word is 10'h01F.
- R8: Lock is lost only after LOSS_N consecutive bad pairs at the locked phase. Up to LOSS_N-1 bad symbols are still delivered as words. The symbol that causes the loss is not delivered.
- R9: After loss of lock, all phases are searched again from zero counts, and a sync stream restores lock.
- R10: While out_en is 0, word and word_stb are 0 and lock_n keeps reporting the alignment state.
- R11: While sleep is 1, lock_n is 1 and all alignment state is cleared. Once sleep is released, lock is found again only through a fresh search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Sampled serial bit, one per clock |
| out_en | input | 1 | Enables word and word_stb |
| sleep | input | 1 | Blanks all outputs and clears alignment state |
| word | output | PAY_W (10) | Recovered payload |
| word_stb | output | 1 | One-cycle pulse per delivered word |
| lock_n | output | 1 | Active-low alignment indication |

## Verification
The bench builds the block with MATCH_N = 4 and LOSS_N = 4. A short acquisition window lets every one of the 1024 payload values be replayed from reset as a repeating stream. Each run's lock decision is compared with a transition count computed in the bench, which covers every single-candidate and multi-candidate pattern. While locked, all 1024 payloads pass through the data path in turn. The loss threshold is probed one symbol below and at LOSS_N, and then the output-enable, sleep and relock cases are exercised.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int SYM_W = 12;
  localparam int PAY_W = 10;
  localparam int PH_W  = $clog2(SYM_W);

  typedef logic [SYM_W-1:0] win_t;
  typedef logic [PAY_W-1:0] pay_t;

  // framing pair: oldest bit in window high, newest low
  function automatic logic pair_ok_of(win_t w);
    return w[SYM_W-1] & ~w[0];
  endfunction

  // payload bit i sits i+1 positions after the start bit
  function automatic pay_t pay_of(win_t w);
    pay_t p;
    for (int i = 0; i < PAY_W; i++) p[i] = w[SYM_W-2-i];
    return p;
  endfunction

  function automatic int unsigned ones_of(logic [SYM_W-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < SYM_W; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/fa_window.sv
module fa_window
  import fa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ser_in,
  output win_t            win,
  output logic [PH_W-1:0] phase
);
  logic [SYM_W-2:0] hist;

  assign win = {hist, ser_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      phase <= '0;
    end else if (clr) begin
      hist  <= '0;
      phase <= '0;
    end else begin
      hist  <= win[SYM_W-2:0];
      phase <= (phase == PH_W'(SYM_W-1)) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/fa_search.sv
module fa_search
  import fa_pkg::*;
#(
  parameter int MATCH_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PH_W-1:0]  phase,
  input  logic             pair_ok,
  output logic [SYM_W-1:0] sat,
  output logic             acq
);
  localparam int CW = $clog2(MATCH_N + 1);

  for (genvar g = 0; g < SYM_W; g++) begin : g_ph
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (phase == PH_W'(g)) begin
        if (!pair_ok)                 cnt <= '0;
        else if (cnt != CW'(MATCH_N)) cnt <= cnt + 1'b1;
      end
    end
    assign sat[g] = (cnt == CW'(MATCH_N));
  end

  // confirmed phase matches again while no rival is saturated
  assign acq = pair_ok & sat[phase] & (ones_of(sat) == 1);
endmodule

// File: rtl/fa_track.sv
module fa_track
  import fa_pkg::*;
#(
  parameter int LOSS_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PH_W-1:0] phase,
  input  logic            pair_ok,
  input  logic            acq,
  input  pay_t            pay,
  input  logic            out_en,
  output logic            locked,
  output logic            tick,
  output logic            drop,
  output logic            emit,
  output pay_t            word_q,
  output logic            stb_q
);
  localparam int BW = (LOSS_N > 2) ? $clog2(LOSS_N) : 1;

  logic [PH_W-1:0] lock_ph;
  logic [BW-1:0]   bad;

  assign tick = locked & (phase == lock_ph);
  assign drop = tick & ~pair_ok & (bad == BW'(LOSS_N-1));
  assign emit = (tick & ~drop) | (~locked & acq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0; lock_ph <= '0; bad <= '0; word_q <= '0; stb_q <= 1'b0;
    end else if (clr) begin
      locked <= 1'b0; lock_ph <= '0; bad <= '0; word_q <= '0; stb_q <= 1'b0;
    end else begin
      if (!locked && acq) begin
        locked  <= 1'b1;
        lock_ph <= phase;
        bad     <= '0;
      end else if (drop) begin
        locked <= 1'b0;
        bad    <= '0;
      end else if (tick) begin
        bad <= pair_ok ? '0 : bad + 1'b1;
      end
      stb_q <= emit & out_en;
      if (emit)      word_q <= pay;
      else if (drop) word_q <= '0;
    end
  end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int MATCH_N = 8,
  parameter int LOSS_N  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_bit,
  input  logic             out_en,
  input  logic             sleep,
  output logic [PAY_W-1:0] word,
  output logic             word_stb,
  output logic             lock_n
);
  win_t             win;
  logic [PH_W-1:0]  phase;
  logic             pair_ok;
  logic [SYM_W-1:0] sat;
  logic             acq, locked, tick, drop, emit, stb_q;
  pay_t             word_q;

  assign pair_ok = pair_ok_of(win);

  fa_window u_win (
    .clk(clk), .rst_n(rst_n), .clr(sleep), .ser_in(ser_bit),
    .win(win), .phase(phase)
  );

  fa_search #(.MATCH_N(MATCH_N)) u_srch (
    .clk(clk), .rst_n(rst_n), .clr(sleep | locked), .phase(phase),
    .pair_ok(pair_ok), .sat(sat), .acq(acq)
  );

  fa_track #(.LOSS_N(LOSS_N)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(sleep), .phase(phase),
    .pair_ok(pair_ok), .acq(acq), .pay(pay_of(win)), .out_en(out_en),
    .locked(locked), .tick(tick), .drop(drop), .emit(emit),
    .word_q(word_q), .stb_q(stb_q)
  );

  assign word     = (locked && out_en) ? word_q : '0;
  assign word_stb = stb_q & out_en;
  assign lock_n   = ~locked;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int LOSS_N = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep,
  input logic        out_en,
  input logic        pair_ok,
  input logic        tick,
  input logic [11:0] sat,
  input logic        lock_n,
  input logic        word_stb,
  input logic [9:0]  word
);
  localparam int CBW = $clog2(LOSS_N + 1);
  logic [CBW-1:0] chk_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_bad <= '0;
    else if (sleep || lock_n)  chk_bad <= '0;
    else if (tick)             chk_bad <= pair_ok ? '0 : chk_bad + 1'b1;
  end

  AST_HOLD_BELOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pair_ok && !sleep && chk_bad < CBW'(LOSS_N-1)) |=> !lock_n); // R8
  AST_DROP_AT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pair_ok && chk_bad == CBW'(LOSS_N-1)) |=> lock_n); // R8
  AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !lock_n); // R3
  AST_BLANK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n |-> (word == '0 && !word_stb)); // R3
  AST_OE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (word == '0 && !word_stb)); // R10
  AST_SLEEP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> lock_n); // R11
  AST_SINGLE_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> ($past($countones(sat)) == 1)); // R6
endmodule

bind frame_aligner fa_checker #(.LOSS_N(LOSS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .out_en(out_en),
  .pair_ok(pair_ok), .tick(tick), .sat(sat), .lock_n(lock_n),
  .word_stb(word_stb), .word(word)
);

// File: tb/sim_frame_aligner.sv
`timescale 1ns/1ps
module sim_frame_aligner;
  localparam int N = 4;
  localparam int L = 4;
  localparam logic [9:0] SYNC_PAY = 10'h01F;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ser_bit = 1'b0, out_en = 1'b1, sleep = 1'b0;
  logic [9:0] word;
  logic word_stb, lock_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [9:0] capq[$];

  always #2.5 clk = ~clk;

  frame_aligner #(.MATCH_N(N), .LOSS_N(L)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .out_en(out_en),
    .sleep(sleep), .word(word), .word_stb(word_stb), .lock_n(lock_n)
  );

  always @(negedge clk) if (word_stb) capq.push_back(word);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_bit = b;
  endtask

  // R1 order: start, payload bit 0..9, stop
  task automatic send_sym(input logic [9:0] p);
    send_bit(1'b1);
    for (int i = 0; i < 10; i++) send_bit(p[i]);
    send_bit(1'b0);
  endtask

  task automatic send_bad();
    for (int i = 0; i < 12; i++) send_bit(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ser_bit = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic int rise_count(input logic [9:0] p);
    logic [11:0] s;
    int n = 0;
    s[0] = 1'b1; s[11] = 1'b0;
    for (int i = 0; i < 10; i++) s[i+1] = p[i];
    for (int i = 0; i < 12; i++) if (!s[i] && s[(i+1)%12]) n++;
    return n;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R2 lock_n", int'(lock_n), 1);
    chk("R2 word_stb", int'(word_stb), 0);
    chk("R2 word", int'(word), 0);

    // R5 / R6 sweep: lock iff exactly one cyclic 0-1 transition
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      repeat (N+4) send_sym(10'(p));
      @(negedge clk);
      if (rise_count(10'(p)) == 1) chk("R5 unique lock", int'(lock_n), 0);
      else                         chk("R6 no false lock", int'(lock_n), 1);
    end

    // R7 sync lock, then R4 data sweep
    do_reset();
    repeat (N+4) send_sym(SYNC_PAY);
    chk("R7 sync lock", int'(lock_n), 0);
    capq.delete();
    for (int p = 0; p < 1024; p++) send_sym(10'(p));
    send_sym(SYNC_PAY);
    chk("R4 word count", capq.size(), 1025);
    if (capq.size() == 1025) begin
      chk("R7 sync word", int'(capq[0]), int'(SYNC_PAY));
      for (int p = 0; p < 1024; p++) chk("R4 word value", int'(capq[p+1]), p);
    end

    // R8 three bad pairs keep lock, bad words still delivered
    capq.delete();
    repeat (L-1) send_bad();
    send_sym(SYNC_PAY);
    chk("R8 held lock", int'(lock_n), 0);
    chk("R8 bad words delivered", capq.size(), L);
    if (capq.size() == L)
      for (int i = 1; i < L; i++) chk("R8 bad word value", int'(capq[i]), 0);
    capq.delete();
    repeat (L) send_bad();
    @(negedge clk); @(negedge clk);
    chk("R8 lock lost", int'(lock_n), 1);
    chk("R8 loss symbol not delivered", capq.size(), L);
    chk("R3 word blank", int'(word), 0);

    // R9 relock after loss
    repeat (N+4) send_sym(SYNC_PAY);
    chk("R9 relock", int'(lock_n), 0);

    // R10 output enable
    out_en = 1'b0;
    capq.delete();
    repeat (3) send_sym(SYNC_PAY);
    chk("R10 no strobe", capq.size(), 0);
    chk("R10 word blank", int'(word), 0);
    chk("R10 lock kept", int'(lock_n), 0);
    out_en = 1'b1;
    repeat (2) send_sym(SYNC_PAY);
    chk("R10 strobes resume", int'(capq.size() > 0), 1);

    // R11 sleep
    @(negedge clk); sleep = 1'b1; ser_bit = 1'b0;
    @(negedge clk);
    chk("R11 lock off", int'(lock_n), 1);
    chk("R11 word blank", int'(word), 0);
    repeat (10) @(negedge clk);
    sleep = 1'b0;
    @(negedge clk);
    chk("R11 state cleared", int'(lock_n), 1);
    repeat (N+4) send_sym(SYNC_PAY);
    chk("R11 relock", int'(lock_n), 0);

    finish_up();
  end
endmodule